// File: doc/BRIEF.md
# Five-Stage Pipelined RISC Core

This block is a small 32-bit in-order processor. Instructions move through five stages: fetch, decode, execute, memory access and result write. The supported set is register-to-register add, subtract, and, or and set-on-less-than, plus add-immediate, word load, word store and branch-if-equal. Instruction storage and data storage are two separate internal arrays, so a fetch and a load or store can happen in the same cycle. Decode produces every control signal. Each signal then travels with its instruction in the stage registers until the stage that uses it.

Every instruction passes through every stage. In a stage it does not need, its control bits are low, so that stage does nothing. The core has no hazard detection, no forwarding and no stall logic. Programs must keep dependent instructions apart and must fill the slots after a branch themselves. Instruction memory is loaded through a write port while reset is held. Two combinational debug ports let the environment read any register and any data word.

The branch decision is taken in the memory stage. The branch target is added up in execute, and the choice of destination register is also made in execute.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high, the program counter returns to 0, all registers and all data words read 0, and every stage register holds an instruction that does nothing.
- R2: Each cycle, the word at index PC/4 of instruction memory is fetched and PC advances by 4. Instructions complete in program order, so the later of two writes to the same register wins.
- R3: Opcode 0x00 selects a register operation by its low six bits: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-on-less-than. The sources are the fields at bits [25:21] and [20:16], and the destination is bits [15:11].
- R4: Opcode 0x08 adds the sign-extended immediate in bits [15:0] to the register at [25:21] and writes the sum to the register at [20:16].
- R5: Opcode 0x23 loads the data word at byte address (register[25:21] + sign-extended immediate) into the register at [20:16]. Opcode 0x2B stores the register at [20:16] to that address and changes no register. A data word is changed only by a store.
- R6: Opcode 0x04 branches when its two source registers are equal. The target is PC+4 plus the sign-extended immediate shifted left by 2. The decision is made in the memory stage, so the three instructions after the branch always complete and a taken branch skips the ones after them.
- R7: A branch whose two source registers differ falls through to the next instruction.
- R8: Register 0 always reads as 0, and writes to it are discarded.
- R9: A value being written in the write stage is seen by a decode-stage read of the same register in the same cycle. A result is therefore available to the third instruction after its producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | $clog2(IMEM_WORDS) | Instruction memory word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_val | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | $clog2(DMEM_WORDS) | Data memory word index for the debug read |
| dbg_mem_val | output | 32 | Contents of the selected data word |

## Verification
The assertions assume that instruction memory is written only while reset is high. They also assume that no program puts a dependent instruction closer than three slots after its producer, and that the three slots after any branch hold only instructions that are safe to execute. The random programs meet these conditions by construction. Every generated instruction is followed by two no-ops, loads and stores use register 0 as base with aligned in-range offsets, and each program ends in a branch-to-self followed by no-ops. The directed program places its branches with three padding slots each.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alusel_e;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  ridx_t;

    // controls consumed in write-back
    typedef struct packed {
        logic reg_write;
        logic mem_to_reg;
    } wb_ctl_t;

    // controls consumed in the memory stage
    typedef struct packed {
        logic mem_read;
        logic mem_write;
        logic branch;
    } m_ctl_t;

    // controls consumed in execute
    typedef struct packed {
        logic   alu_src;
        logic   reg_dst;
        aluop_e alu_op;
    } ex_ctl_t;

    typedef struct packed {
        ex_ctl_t ex;
        m_ctl_t  m;
        wb_ctl_t wb;
    } ctl_t;

    typedef struct packed {
        word_t instr;
        word_t pc4;
    } ifid_t;

    typedef struct packed {
        ex_ctl_t    ex;
        m_ctl_t     m;
        wb_ctl_t    wb;
        word_t      pc4;
        word_t      rs_val;
        word_t      rt_val;
        word_t      imm;
        ridx_t      rt;
        ridx_t      rd;
        logic [5:0] funct;
    } idex_t;

    typedef struct packed {
        m_ctl_t  m;
        wb_ctl_t wb;
        word_t   bta;
        logic    zero;
        word_t   alu_y;
        word_t   st_val;
        ridx_t   dst;
    } exm_t;

    typedef struct packed {
        wb_ctl_t wb;
        word_t   alu_y;
        word_t   ld_val;
        ridx_t   dst;
    } mwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alusel_e alu_pick(input aluop_e op, input logic [5:0] fn);
        alusel_e s;
        case (op)
            AOP_ADD: s = ALU_ADD;
            AOP_SUB: s = ALU_SUB;
            default: begin
                case (fn)
                    FN_SUB:  s = ALU_SUB;
                    FN_AND:  s = ALU_AND;
                    FN_OR:   s = ALU_OR;
                    FN_SLT:  s = ALU_SLT;
                    default: s = ALU_ADD;
                endcase
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        ctl.ex.alu_op = AOP_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctl.ex.reg_dst   = 1'b1;
                ctl.ex.alu_op    = AOP_FUNCT;
                ctl.wb.reg_write = 1'b1;
            end
            OP_LW: begin
                ctl.ex.alu_src    = 1'b1;
                ctl.m.mem_read    = 1'b1;
                ctl.wb.reg_write  = 1'b1;
                ctl.wb.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctl.ex.alu_src  = 1'b1;
                ctl.m.mem_write = 1'b1;
            end
            OP_ADDI: begin
                ctl.ex.alu_src   = 1'b1;
                ctl.wb.reg_write = 1'b1;
            end
            OP_BEQ: begin
                ctl.ex.alu_op = AOP_SUB;
                ctl.m.branch  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int NR  = 32,
    parameter int XW  = 32,
    parameter int NRP = 2,
    parameter int AW  = $clog2(NR)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NRP-1:0][AW-1:0]  ra,
    output logic [NRP-1:0][XW-1:0]  rd,
    input  logic                    we,
    input  logic [AW-1:0]           wa,
    input  logic [XW-1:0]           wd,
    input  logic [AW-1:0]           dbg_a,
    output logic [XW-1:0]           dbg_d
);
    logic [XW-1:0] regs [NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // read ports: register 0 is hard zero, same-cycle write is passed through
    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rd[p] = (ra[p] == '0)            ? '0 :
                       (we && wa == ra[p])      ? wd :
                                                  regs[ra[p]];
    end

    assign dbg_d = regs[dbg_a];
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  aluop_e     op,
    input  logic [5:0] funct,
    input  word_t      a,
    input  word_t      b,
    output word_t      y,
    output logic       zero
);
    alusel_e sel;
    assign sel = alu_pick(op, funct);

    always_comb begin
        case (sel)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [31:0]                   imem_wdata,
    input  logic [4:0]                    dbg_reg_sel,
    output logic [31:0]                   dbg_reg_val,
    input  logic [$clog2(DMEM_WORDS)-1:0] dbg_mem_sel,
    output logic [31:0]                   dbg_mem_val
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    // ---------------- fetch ----------------
    word_t pc_q, pc_next, pc4_f, instr_f;
    logic  pc_src;
    word_t bta_m;
    logic [XLEN-1:0] imem [IMEM_WORDS];

    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    assign instr_f = imem[pc_q[IAW+1:2]];
    assign pc4_f   = pc_q + word_t'(4);
    assign pc_next = pc_src ? bta_m : pc4_f;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    ifid_t ifid_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            ifid_q <= '0;
        end else begin
            ifid_q.instr <= instr_f;
            ifid_q.pc4   <= pc4_f;
        end
    end

    // ---------------- decode ----------------
    ctl_t ctl_d;
    pipe5_decode u_dec (
        .opcode (ifid_q.instr[31:26]),
        .ctl    (ctl_d)
    );

    logic [1:0][RAW-1:0] rf_ra;
    logic [1:0][XLEN-1:0] rf_rd;
    logic  wb_we;
    ridx_t wb_addr;
    word_t wb_data;

    assign rf_ra[0] = ifid_q.instr[25:21];
    assign rf_ra[1] = ifid_q.instr[20:16];

    pipe5_regfile #(.NR(NREG), .XW(XLEN), .NRP(2), .AW(RAW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra    (rf_ra),
        .rd    (rf_rd),
        .we    (wb_we),
        .wa    (wb_addr),
        .wd    (wb_data),
        .dbg_a (dbg_reg_sel),
        .dbg_d (dbg_reg_val)
    );

    idex_t idex_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= '0;
        end else begin
            idex_q.ex     <= ctl_d.ex;
            idex_q.m      <= ctl_d.m;
            idex_q.wb     <= ctl_d.wb;
            idex_q.pc4    <= ifid_q.pc4;
            idex_q.rs_val <= rf_rd[0];
            idex_q.rt_val <= rf_rd[1];
            idex_q.imm    <= sext16(ifid_q.instr[15:0]);
            idex_q.rt     <= ifid_q.instr[20:16];
            idex_q.rd     <= ifid_q.instr[15:11];
            idex_q.funct  <= ifid_q.instr[5:0];
        end
    end

    // ---------------- execute ----------------
    word_t alu_b_e, alu_y_e, bta_e;
    logic  zero_e;
    ridx_t dst_e;

    assign alu_b_e = idex_q.ex.alu_src ? idex_q.imm : idex_q.rt_val;

    pipe5_alu u_alu (
        .op    (idex_q.ex.alu_op),
        .funct (idex_q.funct),
        .a     (idex_q.rs_val),
        .b     (alu_b_e),
        .y     (alu_y_e),
        .zero  (zero_e)
    );

    // target adder kept apart from the ALU
    assign bta_e = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
    assign dst_e = idex_q.ex.reg_dst ? idex_q.rd : idex_q.rt;

    exm_t exm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            exm_q <= '0;
        end else begin
            exm_q.m      <= idex_q.m;
            exm_q.wb     <= idex_q.wb;
            exm_q.bta    <= bta_e;
            exm_q.zero   <= zero_e;
            exm_q.alu_y  <= alu_y_e;
            exm_q.st_val <= idex_q.rt_val;
            exm_q.dst    <= dst_e;
        end
    end

    // ---------------- memory ----------------
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [DAW-1:0]  daddr_m;
    word_t           ld_m;

    assign daddr_m = exm_q.alu_y[DAW+1:2];
    assign ld_m    = exm_q.m.mem_read ? dmem[daddr_m] : '0;
    assign pc_src  = exm_q.m.branch & exm_q.zero;
    assign bta_m   = exm_q.bta;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
        end else if (exm_q.m.mem_write) begin
            dmem[daddr_m] <= exm_q.st_val;
        end
    end

    assign dbg_mem_val = dmem[dbg_mem_sel];

    mwb_t mwb_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            mwb_q <= '0;
        end else begin
            mwb_q.wb     <= exm_q.wb;
            mwb_q.alu_y  <= exm_q.alu_y;
            mwb_q.ld_val <= ld_m;
            mwb_q.dst    <= exm_q.dst;
        end
    end

    // ---------------- write-back ----------------
    assign wb_we   = mwb_q.wb.reg_write;
    assign wb_addr = mwb_q.dst;
    assign wb_data = mwb_q.wb.mem_to_reg ? mwb_q.ld_val : mwb_q.alu_y;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input word_t      pc,
    input logic       pc_src,
    input word_t      bta,
    input ridx_t      rs_addr,
    input word_t      rs_data,
    input logic       wb_we,
    input ridx_t      wb_addr,
    input word_t      wb_data,
    input logic [2:0] m_flags
);
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !pc_src |=> pc == $past(pc) + word_t'(4)); // R2

    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
        pc_src |=> pc == $past(bta)); // R6

    AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
        (rs_addr == '0) |-> (rs_data == '0)); // R8

    AST_WB_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (wb_we && wb_addr != '0 && wb_addr == rs_addr) |-> (rs_data == wb_data)); // R9

    AST_M_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_flags)); // R5
endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_q),
    .pc_src  (pc_src),
    .bta     (bta_m),
    .rs_addr (rf_ra[0]),
    .rs_data (rf_rd[0]),
    .wb_we   (wb_we),
    .wb_addr (wb_addr),
    .wb_data (wb_data),
    .m_flags ({exm_q.m.mem_write, exm_q.m.branch, exm_q.wb.reg_write})
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;
    import pipe5_pkg::*;

    localparam int IW = 64;
    localparam int DW = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);
    localparam logic [31:0] NOP = 32'h0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic            imem_we = 1'b0;
    logic [IAW-1:0]  imem_waddr = '0;
    logic [31:0]     imem_wdata = '0;
    logic [4:0]      dbg_reg_sel = '0;
    logic [31:0]     dbg_reg_val;
    logic [DAW-1:0]  dbg_mem_sel = '0;
    logic [31:0]     dbg_mem_val;

    pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .imem_we     (imem_we),
        .imem_waddr  (imem_waddr),
        .imem_wdata  (imem_wdata),
        .dbg_reg_sel (dbg_reg_sel),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel),
        .dbg_mem_val (dbg_mem_val)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] prog  [IW];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [DW];

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {OP_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic get_reg(input int idx, output logic [31:0] v);
        dbg_reg_sel = 5'(idx);
        #1;
        v = dbg_reg_val;
    endtask

    task automatic get_mem(input int idx, output logic [31:0] v);
        dbg_mem_sel = DAW'(idx);
        #1;
        v = dbg_mem_val;
    endtask

    // hold reset, load the program, check the cleared state, release and run
    task automatic load_run(input int cycles);
        logic [31:0] v;
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < IW; i++) begin
            imem_we    = 1'b1;
            imem_waddr = IAW'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            get_reg(i, v);
            check("R1", $sformatf("reg %0d under reset", i), v, 32'h0);
        end
        for (int i = 0; i < DW; i++) begin
            get_mem(i, v);
            check("R1", $sformatf("mem %0d under reset", i), v, 32'h0);
        end
        @(negedge clk);
        rst = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic build_random(input int n_ops);
        for (int i = 0; i < IW; i++) prog[i] = NOP;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < DW; i++) m_mem[i] = '0;
        for (int k = 0; k < n_ops; k++) begin
            int op = int'($urandom % 8);
            int rs = int'($urandom % 8);
            int rt = int'($urandom % 8);
            int rd = int'($urandom % 8);
            logic [15:0] imm = 16'($urandom);
            int widx = int'($urandom % DW);
            logic [31:0] res;
            logic [31:0] a = m_reg[rs];
            logic [31:0] b = m_reg[rt];
            case (op)
                0: begin
                    prog[3*k] = enc_i(OP_ADDI, rs, rt, imm);
                    if (rt != 0) m_reg[rt] = a + sx(imm);
                end
                6: begin
                    prog[3*k] = enc_i(OP_SW, 0, rt, 16'(widx*4));
                    m_mem[widx] = b;
                end
                7: begin
                    prog[3*k] = enc_i(OP_LW, 0, rt, 16'(widx*4));
                    if (rt != 0) m_reg[rt] = m_mem[widx];
                end
                default: begin
                    logic [5:0] fn;
                    case (op)
                        1: begin fn = FN_ADD; res = a + b; end
                        2: begin fn = FN_SUB; res = a - b; end
                        3: begin fn = FN_AND; res = a & b; end
                        4: begin fn = FN_OR;  res = a | b; end
                        default: begin fn = FN_SLT; res = {31'd0, $signed(a) < $signed(b)}; end
                    endcase
                    prog[3*k] = enc_r(rs, rt, rd, fn);
                    if (rd != 0) m_reg[rd] = res;
                end
            endcase
        end
        prog[3*n_ops] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
    endtask

    initial begin
        logic [31:0] v;
        v = $urandom(32'h5EED_0042);

        // constrained random straight-line programs, two no-ops after each op
        for (int run = 0; run < 3; run++) begin
            build_random(18);
            load_run(110);
            for (int i = 0; i < 32; i++) begin
                get_reg(i, v);
                check(i == 0 ? "R8" : "R3", $sformatf("run %0d reg %0d", run, i), v, m_reg[i]);
            end
            for (int i = 0; i < DW; i++) begin
                get_mem(i, v);
                check("R5", $sformatf("run %0d mem %0d", run, i), v, m_mem[i]);
            end
        end

        // directed program
        for (int i = 0; i < IW; i++) prog[i] = NOP;
        prog[0]  = enc_i(OP_ADDI, 0, 1, 16'd5);
        prog[3]  = enc_i(OP_ADDI, 1, 1, 16'd4);      // reads r1 with exactly two no-ops between
        prog[6]  = enc_i(OP_ADDI, 0, 5, 16'hFFFF);
        prog[9]  = enc_r(5, 0, 6, FN_SLT);
        prog[10] = enc_i(OP_ADDI, 0, 0, 16'd7);
        prog[13] = enc_r(0, 1, 7, FN_ADD);
        prog[14] = enc_i(OP_SW, 0, 1, 16'd8);
        prog[17] = enc_i(OP_LW, 0, 8, 16'd8);
        prog[18] = enc_i(OP_BEQ, 1, 0, 16'd5);       // not taken
        prog[19] = enc_i(OP_ADDI, 0, 9, 16'd1);
        prog[22] = enc_i(OP_ADDI, 0, 10, 16'd2);
        prog[24] = enc_i(OP_BEQ, 0, 0, 16'd4);       // taken, target index 29
        prog[25] = enc_i(OP_ADDI, 0, 11, 16'd3);
        prog[28] = enc_i(OP_ADDI, 0, 12, 16'd4);
        prog[29] = enc_i(OP_ADDI, 0, 13, 16'd5);
        prog[30] = enc_i(OP_BEQ, 0, 0, 16'hFFFF);
        load_run(80);

        get_reg(1, v);  check("R9", "r1 after bypassed read", v, 32'd9);
        check("R2", "r1 holds later write", v, 32'd9);
        get_reg(5, v);  check("R4", "addi negative immediate", v, 32'hFFFF_FFFF);
        get_reg(6, v);  check("R3", "signed slt of -1 vs 0", v, 32'd1);
        get_reg(0, v);  check("R8", "r0 after write attempt", v, 32'd0);
        get_reg(7, v);  check("R8", "r0 reads zero as source", v, 32'd9);
        get_mem(2, v);  check("R5", "stored word", v, 32'd9);
        get_reg(8, v);  check("R5", "loaded word", v, 32'd9);
        get_reg(9, v);  check("R7", "slot after untaken branch", v, 32'd1);
        get_reg(10, v); check("R7", "fall-through instruction", v, 32'd2);
        get_reg(11, v); check("R6", "delay slot of taken branch", v, 32'd3);
        get_reg(12, v); check("R6", "skipped instruction", v, 32'd0);
        get_reg(13, v); check("R6", "branch target instruction", v, 32'd5);
        get_mem(3, v);  check("R5", "untouched data word", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog expired: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule